// File: doc/BRIEF.md
# Bus-Master DMA Channel Control Registers

This block is the host-facing register set of one bus-master DMA channel. A host reaches it through a small byte-addressed I/O window of eight bytes: a command byte at offset 0, a status byte at offset 2 and a 32-bit descriptor-table base address at offsets 4 to 7. Accesses are one byte, one halfword or one word wide. Reads are combinational from the registers; writes take effect at the clock edge on which the write strobe is sampled.

Toward the DMA engine the block drives one-cycle control pulses (kick, cancel, reload of the table pointer), the transfer direction and the current descriptor-table pointer. The engine reports back by advancing the pointer, signalling the end of the table and flagging errors. The device interrupt line passes straight through to the host, and its rising edge also sets a sticky interrupt flag in status that the host clears by writing a one to it.

Top module: `bmdma_regs`

## Requirements
- R1: A command write (h_addr 0) keeps only bit 0 (start) and bit 3 (direction, driven on eng_dir); reading h_addr 0 returns those two bits in place and zero in all other bits of h_rdata.
- R2: A command write whose bit 0 equals the stored start bit produces no kick, cancel or reload pulse and leaves status unchanged; only the stored direction updates.
- R3: A command write that changes start from 0 to 1 copies the base address into eng_ptr and pulses eng_reload for the cycle after the write; if status bit 0 (active) was clear it is set and eng_kick pulses in that same cycle.
- R4: A command write that changes start from 1 to 0 pulses eng_cancel for the cycle after the write and clears the active bit.
- R5: Writes to h_addr 4..7 with h_size 0 (byte), 1 (halfword) or 2 (word) replace only the byte lanes from offset h_addr-4 upward, taking data from the low bits of h_wdata; lanes past byte 3 are dropped and base bits 1:0 always stay zero.
- R6: Reads of h_addr 4..7 return the base shifted right by 8*(h_addr-4) bits and masked to the access width; reads of h_addr 1 and 3 return zero.
- R7: host_irq equals dev_irq combinationally; a rising edge of dev_irq sets status bit 2 (interrupt) at the next edge, and a falling edge leaves status alone.
- R8: A status write (h_addr 2) clears bit 1 (error) or bit 2 (interrupt) where the written byte has a one; bit 0 is unaffected by status writes; status bits 7:3 read zero.
- R9: eng_done clears the active bit and eng_err sets status bit 1; in the same cycle an event wins over a host clear of the same bit, and a start rising edge wins over eng_done.
- R10: eng_adv advances eng_ptr by 8; a reload in the same cycle wins.
- R11: Reset clears command, status, base address and eng_ptr, and holds all control pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 3 | Byte offset in the register window |
| h_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| h_wdata | input | 32 | Write data, low-aligned |
| h_rdata | output | 32 | Read data for h_addr/h_size |
| eng_kick | output | 1 | Start the engine (one cycle) |
| eng_cancel | output | 1 | Abort an in-flight transfer (one cycle) |
| eng_reload | output | 1 | Table pointer reloaded from base (one cycle) |
| eng_dir | output | 1 | Stored direction bit |
| eng_ptr | output | 32 | Current descriptor-table pointer |
| eng_adv | input | 1 | Engine consumed one descriptor |
| eng_done | input | 1 | Engine reached the end of the table |
| eng_err | input | 1 | Engine error event |
| dev_irq | input | 1 | Device interrupt line |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
A wrong start-edge decision shows at the control pulses in the very cycle after the command write, and as a wrong active bit on the next status read. A faulty lane merge in the base register surfaces at the next read of any lane it touched and again at the next reload, when eng_ptr takes the corrupted value. A lost or stuck interrupt flag shows on the status read right after the dev_irq edge or the clearing write, so each error is visible within one or two cycles of its cause.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  // Width mask for an access of the given size
  function automatic logic [REG_W-1:0] size_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // Merge a low-aligned write into the lanes starting at byte offset off
  function automatic logic [REG_W-1:0] merge_lanes(input logic [REG_W-1:0] old,
                                                   input logic [REG_W-1:0] data,
                                                   input logic [1:0] off,
                                                   input logic [1:0] sz);
    logic [REG_W-1:0] m;
    logic [REG_W-1:0] v;
    m = size_mask(sz) << {off, 3'b000};
    v = (old & ~m) | ((data & size_mask(sz)) << {off, 3'b000});
    return v & ~32'h3;
  endfunction

  // Extract the lanes selected by offset and size
  function automatic logic [REG_W-1:0] pick_lanes(input logic [REG_W-1:0] v,
                                                  input logic [1:0] off,
                                                  input logic [1:0] sz);
    return (v >> {off, 3'b000}) & size_mask(sz);
  endfunction
endpackage

// File: rtl/bmdma_cmd.sv
module bmdma_cmd #(
  parameter int START_BIT = 0,
  parameter int DIR_BIT   = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_we,
  input  logic [7:0] cmd_byte,
  input  logic       active,
  output logic       start_q,
  output logic       dir_q,
  output logic       start_rise,
  output logic       start_fall,
  output logic       kick_o,
  output logic       cancel_o,
  output logic       reload_o
);
  logic new_start;
  assign new_start  = cmd_byte[START_BIT];
  assign start_rise = cmd_we && new_start && !start_q;
  assign start_fall = cmd_we && !new_start && start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q  <= 1'b0;
      dir_q    <= 1'b0;
      kick_o   <= 1'b0;
      cancel_o <= 1'b0;
      reload_o <= 1'b0;
    end else begin
      if (cmd_we) begin
        start_q <= new_start;
        dir_q   <= cmd_byte[DIR_BIT];
      end
      kick_o   <= start_rise && !active;
      cancel_o <= start_fall;
      reload_o <= start_rise;
    end
  end

  p_same_start_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (new_start == start_q)) |=> (!kick_o && !cancel_o && !reload_o));
  p_kick_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_o |-> active);
  p_cancel_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |-> !active);
endmodule

// File: rtl/bmdma_status.sv
module bmdma_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       st_we,
  input  logic [7:0] st_byte,
  input  logic       start_rise,
  input  logic       start_fall,
  input  logic       eng_done,
  input  logic       eng_err,
  input  logic       dev_irq,
  output logic [2:0] status_q
);
  logic st_act, st_err, st_int;
  logic irq_prev;
  logic irq_rise;
  logic clr_err, clr_int;

  assign irq_rise = dev_irq && !irq_prev;
  assign clr_err  = st_we && st_byte[1];
  assign clr_int  = st_we && st_byte[2];
  assign status_q = {st_int, st_err, st_act};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_act   <= 1'b0;
      st_err   <= 1'b0;
      st_int   <= 1'b0;
      irq_prev <= 1'b0;
    end else begin
      irq_prev <= dev_irq;
      if (start_rise)      st_act <= 1'b1;
      else if (start_fall) st_act <= 1'b0;
      else if (eng_done)   st_act <= 1'b0;
      if (eng_err)         st_err <= 1'b1;
      else if (clr_err)    st_err <= 1'b0;
      if (irq_rise)        st_int <= 1'b1;
      else if (clr_int)    st_int <= 1'b0;
    end
  end

  p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> st_int);
  p_err_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_err |=> st_err);
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !start_rise) |=> !st_act);
  p_act_readonly_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && !start_rise && !start_fall && !eng_done) |=> (st_act == $past(st_act)));
endmodule

// File: rtl/bmdma_base.sv
module bmdma_base
  import bmdma_pkg::*;
#(
  parameter int DESC_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_we,
  input  logic [1:0]       off,
  input  logic [1:0]       sz,
  input  logic [REG_W-1:0] wdata,
  input  logic             reload,
  input  logic             adv,
  output logic [REG_W-1:0] base_q,
  output logic [REG_W-1:0] ptr_q
);
  localparam logic [REG_W-1:0] STEP = REG_W'(DESC_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (base_we) base_q <= merge_lanes(base_q, wdata, off, sz);
      if (reload)   ptr_q <= base_q;
      else if (adv) ptr_q <= ptr_q + STEP;
    end
  end

  p_reload_copy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (ptr_q == $past(base_q)));
  p_adv_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !reload) |=> (ptr_q == $past(ptr_q) + STEP));
  p_base_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |=> (base_q[1:0] == 2'b00));
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int DESC_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             h_wr,
  input  logic [2:0]       h_addr,
  input  logic [1:0]       h_size,
  input  logic [REG_W-1:0] h_wdata,
  output logic [REG_W-1:0] h_rdata,
  output logic             eng_kick,
  output logic             eng_cancel,
  output logic             eng_reload,
  output logic             eng_dir,
  output logic [REG_W-1:0] eng_ptr,
  input  logic             eng_adv,
  input  logic             eng_done,
  input  logic             eng_err,
  input  logic             dev_irq,
  output logic             host_irq
);
  localparam logic [2:0] A_CMD  = 3'd0;
  localparam logic [2:0] A_STAT = 3'd2;

  logic             sel_cmd, sel_stat, sel_base;
  logic             start_q, dir_q, start_rise, start_fall;
  logic [2:0]       status_q;
  logic [REG_W-1:0] base_q;
  logic [1:0]       lane_off;

  assign sel_cmd  = (h_addr == A_CMD);
  assign sel_stat = (h_addr == A_STAT);
  assign sel_base = h_addr[2];
  assign lane_off = h_addr[1:0];

  bmdma_cmd u_cmd (
    .clk(clk), .rst_n(rst_n),
    .cmd_we(h_wr && sel_cmd), .cmd_byte(h_wdata[7:0]),
    .active(status_q[0]),
    .start_q(start_q), .dir_q(dir_q),
    .start_rise(start_rise), .start_fall(start_fall),
    .kick_o(eng_kick), .cancel_o(eng_cancel), .reload_o(eng_reload)
  );

  bmdma_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .st_we(h_wr && sel_stat), .st_byte(h_wdata[7:0]),
    .start_rise(start_rise), .start_fall(start_fall),
    .eng_done(eng_done), .eng_err(eng_err), .dev_irq(dev_irq),
    .status_q(status_q)
  );

  bmdma_base #(.DESC_BYTES(DESC_BYTES)) u_base (
    .clk(clk), .rst_n(rst_n),
    .base_we(h_wr && sel_base), .off(lane_off), .sz(h_size),
    .wdata(h_wdata), .reload(start_rise), .adv(eng_adv),
    .base_q(base_q), .ptr_q(eng_ptr)
  );

  assign eng_dir  = dir_q;
  assign host_irq = dev_irq;

  always_comb begin
    h_rdata = '0;
    if (sel_base)      h_rdata = pick_lanes(base_q, lane_off, h_size);
    else if (sel_cmd)  h_rdata = {28'd0, dir_q, 2'b00, start_q};
    else if (sel_stat) h_rdata = {29'd0, status_q};
  end

  p_irq_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == dev_irq);
  p_cmd_zero_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cmd && !h_wr) |-> (h_rdata[7:4] == 4'd0 && h_rdata[2:1] == 2'd0));
  p_stat_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sel_stat |-> (h_rdata[7:3] == 5'd0));
endmodule

// File: tb/bmdma_regs_test.sv
module bmdma_regs_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        h_wr = 0;
  logic [2:0]  h_addr = 0;
  logic [1:0]  h_size = 0;
  logic [31:0] h_wdata = 0;
  logic [31:0] h_rdata;
  logic        eng_kick, eng_cancel, eng_reload, eng_dir, host_irq;
  logic [31:0] eng_ptr;
  logic        eng_adv = 0, eng_done = 0, eng_err = 0, dev_irq = 0;

  int checks = 0;
  int errors = 0;

  // bench model
  logic        m_start, m_dir, m_act, m_err, m_int, m_prev_irq;
  logic [31:0] m_base, m_ptr;
  logic        m_kick, m_cancel, m_reload;

  bmdma_regs uut (
    .clk(clk), .rst_n(rst_n), .h_wr(h_wr), .h_addr(h_addr), .h_size(h_size),
    .h_wdata(h_wdata), .h_rdata(h_rdata), .eng_kick(eng_kick),
    .eng_cancel(eng_cancel), .eng_reload(eng_reload), .eng_dir(eng_dir),
    .eng_ptr(eng_ptr), .eng_adv(eng_adv), .eng_done(eng_done),
    .eng_err(eng_err), .dev_irq(dev_irq), .host_irq(host_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] width_bits(input logic [1:0] sz);
    if (sz == 2'd0) return 32'hFF;
    if (sz == 2'd1) return 32'hFFFF;
    return 32'hFFFFFFFF;
  endfunction

  function automatic int byte_count(input logic [1:0] sz);
    if (sz == 2'd0) return 1;
    if (sz == 2'd1) return 2;
    return 4;
  endfunction

  // Expected read value for an address, from the model
  function automatic logic [31:0] model_read(input logic [2:0] a, input logic [1:0] sz);
    logic [31:0] r;
    r = 32'd0;
    if (a >= 3'd4) begin
      for (int k = 0; k < 4; k++)
        if (int'(a) - 4 + k < 4) r[8*k +: 8] = m_base[8*(int'(a) - 4 + k) +: 8];
      r = r & width_bits(sz);
    end else if (a == 3'd0) begin
      r[0] = m_start; r[3] = m_dir;
    end else if (a == 3'd2) begin
      r[0] = m_act; r[1] = m_err; r[2] = m_int;
    end
    return r;
  endfunction

  task automatic model_reset();
    m_start = 0; m_dir = 0; m_act = 0; m_err = 0; m_int = 0; m_prev_irq = 0;
    m_base = 0; m_ptr = 0; m_kick = 0; m_cancel = 0; m_reload = 0;
  endtask

  // One clock step: drive at negedge, clock, update model, check outputs
  task automatic step(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic adv, input logic done,
                      input logic err, input logic irq);
    logic rise, fall, n_start, irq_up;
    logic [31:0] nb;
    h_wr = wr; h_addr = a; h_size = sz; h_wdata = d;
    eng_adv = adv; eng_done = done; eng_err = err; dev_irq = irq;
    #1;
    check("R7", "host_irq pass-through", {31'd0, host_irq}, {31'd0, irq});
    @(posedge clk);
    n_start = d[0];
    rise = wr && a == 3'd0 && n_start && !m_start;
    fall = wr && a == 3'd0 && !n_start && m_start;
    irq_up = irq && !m_prev_irq;
    m_kick = rise && !m_act;
    m_cancel = fall;
    m_reload = rise;
    if (rise) m_ptr = m_base;
    else if (adv) m_ptr = m_ptr + 32'd8;
    if (rise) m_act = 1;
    else if (fall) m_act = 0;
    else if (done) m_act = 0;
    if (err) m_err = 1;
    else if (wr && a == 3'd2 && d[1]) m_err = 0;
    if (irq_up) m_int = 1;
    else if (wr && a == 3'd2 && d[2]) m_int = 0;
    m_prev_irq = irq;
    if (wr && a == 3'd0) begin m_start = n_start; m_dir = d[3]; end
    if (wr && a >= 3'd4) begin
      nb = m_base;
      for (int k = 0; k < byte_count(sz); k++)
        if (int'(a) - 4 + k < 4) nb[8*(int'(a) - 4 + k) +: 8] = d[8*k +: 8];
      nb[1:0] = 2'b00;
      m_base = nb;
    end
    @(negedge clk);
    h_wr = 0; eng_adv = 0; eng_done = 0; eng_err = 0;
    check("R3", "kick pulse", {31'd0, eng_kick}, {31'd0, m_kick});
    check("R4", "cancel pulse", {31'd0, eng_cancel}, {31'd0, m_cancel});
    check("R2", "reload pulse", {31'd0, eng_reload}, {31'd0, m_reload});
    check("R10", "table pointer", eng_ptr, m_ptr);
    check("R1", "direction out", {31'd0, eng_dir}, {31'd0, m_dir});
  endtask

  task automatic read_chk(input string req, input logic [2:0] a, input logic [1:0] sz);
    h_wr = 0; h_addr = a; h_size = sz;
    #1;
    check(req, $sformatf("read addr %0d size %0d", a, sz), h_rdata, model_read(a, sz));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    model_reset();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check("R11", "ptr after reset", eng_ptr, 32'd0);
    check("R11", "pulses after reset", {29'd0, eng_kick, eng_cancel, eng_reload}, 32'd0);
    read_chk("R11", 3'd0, 2'd0);
    read_chk("R11", 3'd2, 2'd0);
    read_chk("R11", 3'd4, 2'd2);
    rst_n = 1;

    // R5/R6: directed base writes
    step(1, 3'd4, 2'd2, 32'h1234_567F, 0, 0, 0, 0);
    read_chk("R5", 3'd4, 2'd2);
    check("R5", "low bits zero", h_rdata, 32'h1234_567C);
    step(1, 3'd6, 2'd1, 32'hFFFF_ABCD, 0, 0, 0, 0);
    read_chk("R5", 3'd4, 2'd2);
    check("R5", "half at offset 2", h_rdata, 32'hABCD_567C);
    step(1, 3'd7, 2'd2, 32'h1122_3344, 0, 0, 0, 0);
    read_chk("R5", 3'd4, 2'd2);
    check("R5", "word at offset 3 truncated", h_rdata, 32'h44CD_567C);
    read_chk("R6", 3'd5, 2'd0);
    check("R6", "byte read offset 1", h_rdata, 32'h0000_0056);
    read_chk("R6", 3'd3, 2'd2);

    // R1/R3: start rising with direction and junk bits
    step(1, 3'd0, 2'd0, 32'hFFFF_FFF9, 0, 0, 0, 0);
    check("R3", "kick on start", {31'd0, eng_kick}, 32'd1);
    check("R3", "ptr reloaded", eng_ptr, 32'h44CD_567C);
    read_chk("R1", 3'd0, 2'd0);
    check("R1", "cmd readback", h_rdata, 32'h0000_0009);
    // R2: same start, direction changes
    step(1, 3'd0, 2'd0, 32'h0000_0001, 1, 0, 0, 0);
    check("R2", "no kick when start unchanged", {31'd0, eng_kick}, 32'd0);
    read_chk("R2", 3'd2, 2'd0);
    // R9: engine done and error with host clear in same cycle
    step(1, 3'd2, 2'd0, 32'h0000_0007, 0, 1, 1, 0);
    read_chk("R9", 3'd2, 2'd0);
    check("R9", "done clears active, error wins", h_rdata, 32'h0000_0002);
    // R4: stop
    step(1, 3'd0, 2'd0, 32'h0000_0000, 0, 0, 0, 0);
    check("R4", "cancel on stop", {31'd0, eng_cancel}, 32'd1);
    // R7/R8: interrupt rise, fall, clear
    step(0, 3'd0, 2'd0, 32'd0, 0, 0, 0, 1);
    read_chk("R7", 3'd2, 2'd0);
    step(0, 3'd0, 2'd0, 32'd0, 0, 0, 0, 0);
    read_chk("R7", 3'd2, 2'd0);
    step(1, 3'd2, 2'd0, 32'h0000_0007, 0, 0, 0, 0);
    read_chk("R8", 3'd2, 2'd0);
    check("R8", "W1C clears error and interrupt", h_rdata, 32'd0);
    // R10: reload wins over adv
    step(1, 3'd0, 2'd0, 32'h0000_0001, 1, 0, 0, 0);
    check("R10", "reload wins", eng_ptr, 32'h44CD_567C);

    // constrained random
    for (int i = 0; i < 600; i++) begin
      logic [2:0] a;
      logic [1:0] sz;
      logic [31:0] d;
      a = 3'($urandom_range(0, 7));
      sz = 2'($urandom_range(0, 2));
      d = $urandom;
      step(($urandom_range(0, 3) != 0), a, sz, d,
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
           ($urandom_range(0, 7) == 0), ($urandom_range(0, 2) == 0));
      read_chk("R1", 3'd0, 2'd0);
      read_chk("R8", 3'd2, 2'd0);
      read_chk("R6", 3'($urandom_range(4, 7)), 2'($urandom_range(0, 2)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule